// File: doc/BRIEF.md
# Memory-Mapped GPIO Bank with Atomic Bit Operations

This block is a 32-pin general-purpose I/O bank reached through a plain word-addressed register port. Software drives pins through an output latch and picks each pin's direction through a direction register. Three write-only mask registers change chosen latch bits in one bus write each, without a read-modify-write: one forces bits high, one forces them low, one inverts them. A read-only input register returns the pin levels after a two-flop synchronizer.

The bus side is a single-cycle strobe interface. A write is taken on any clock edge where `bus_wr` is high. A read is taken on any clock edge where `bus_rd` is high. Its data appears on `bus_rdata` one cycle later, with `bus_rvalid` high for exactly that cycle. The port never applies back-pressure: it takes one read and one write per cycle, both to the same address, so there is no ready signal. The address is a word index, so byte offset = index × 4.

The pin side presents per-pin output value (`pin_out`), output enable (`pin_oe`) and raw input (`pin_in`). A tri-state pad combines them outside this block.

Top module: `gpio_bank`

## Requirements
- R1: While reset is held low and just after it is released, the output latch and the direction register are all zeros, so `pin_out` = 0 and `pin_oe` = 0. Every pin is an input.
- R2: A write to word index 0 (byte offset 0x00) loads the output latch with `bus_wdata`. `pin_out` shows the new value one cycle later, and a read of index 0 returns the latch.
- R3: A write to index 1 (0x04) sets to 1 every latch bit whose written bit is 1. The other latch bits keep their values.
- R4: A write to index 2 (0x08) clears to 0 every latch bit whose written bit is 1. The other latch bits keep their values.
- R5: A write to index 3 (0x0C) inverts every latch bit whose written bit is 1. The other latch bits keep their values.
- R6: Reads of indices 1, 2 and 3 return 0.
- R7: A read of index 4 (0x10) returns `pin_in` after two synchronizer flops. A pin change made before a clock edge is therefore not seen by a read taken on the second edge after it. A write to index 4 changes nothing.
- R8: Index 5 (0x14) is the direction register, readable and writable. Bit value 1 means output. `pin_oe` equals the register.
- R9: `bus_rvalid` is high in exactly the cycle after each accepted read, and `bus_rdata` is valid in that cycle. When a read and a write to the same register are taken on one edge, the read returns the value from before the write.
- R10: Indices 6 and 7 read as 0, and writes to them change neither the latch nor the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid when bus_rvalid is high |
| bus_rvalid | output | 1 | High in the cycle after an accepted read |
| pin_in | input | 32 | Raw pin levels, asynchronous |
| pin_out | output | 32 | Per-pin output value |
| pin_oe | output | 32 | Per-pin output enable |

## Verification
A read and a write can be taken on the same edge. The bench provokes this by raising both strobes in one cycle on the output latch, with a new write value. The scoreboard expects the value from before the write, and a follow-up read must then return the new value. The synchronizer's latency is judged the same way. A read issued one cycle after a pin change must still return the old level, and the read after it must return the new level.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [2:0] {
    SLOT_DOUT = 3'd0,
    SLOT_SET  = 3'd1,
    SLOT_CLR  = 3'd2,
    SLOT_TGL  = 3'd3,
    SLOT_PIN  = 3'd4,
    SLOT_DIR  = 3'd5,
    SLOT_RSV6 = 3'd6,
    SLOT_RSV7 = 3'd7
  } slot_e;

  typedef struct packed {
    logic ld;
    logic set;
    logic clr;
    logic tgl;
    logic dir;
  } wr_strobes_t;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output wr_strobes_t       stb
);
  slot_e slot;

  always_comb begin
    slot = slot_e'(addr[2:0]);
    stb  = '0;
    if (wr) begin
      unique case (slot)
        SLOT_DOUT: stb.ld  = 1'b1;
        SLOT_SET:  stb.set = 1'b1;
        SLOT_CLR:  stb.clr = 1'b1;
        SLOT_TGL:  stb.tgl = 1'b1;
        SLOT_DIR:  stb.dir = 1'b1;
        default:   stb     = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_outlatch.sv
module gpio_bank_outlatch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] set_mask,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] tgl_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] after_ld, after_set, after_clr, nxt;

  // Fixed order: load, then set, then clear, then toggle.
  always_comb begin
    after_ld  = ld_en ? ld_val : q;
    after_set = after_ld | set_mask;
    after_clr = after_set & ~clr_mask;
    nxt       = after_clr ^ tgl_mask;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) q <= '0;
    else        q <= nxt;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic [DATA_W-1:0] pin_oe
);
  localparam logic [DATA_W-1:0] ZERO_W = '0;

  wr_strobes_t       stb;
  logic [DATA_W-1:0] latch_q, dir_q, pin_sync, rd_mux;
  slot_e             rd_slot;

  gpio_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .wr   (bus_wr),
    .addr (bus_addr),
    .stb  (stb)
  );

  gpio_bank_outlatch #(.W(DATA_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (stb.ld),
    .ld_val   (bus_wdata),
    .set_mask (stb.set ? bus_wdata : ZERO_W),
    .clr_mask (stb.clr ? bus_wdata : ZERO_W),
    .tgl_mask (stb.tgl ? bus_wdata : ZERO_W),
    .q        (latch_q)
  );

  gpio_bank_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      dir_q <= '0;
    else if (stb.dir) dir_q <= bus_wdata;

  always_comb begin
    rd_slot = slot_e'(bus_addr[2:0]);
    unique case (rd_slot)
      SLOT_DOUT: rd_mux = latch_q;
      SLOT_PIN:  rd_mux = pin_sync;
      SLOT_DIR:  rd_mux = dir_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end

  assign pin_out = latch_q;
  assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [DATA_W-1:0] pin_out,
  input logic [DATA_W-1:0] pin_oe
);
  logic zero_slot;
  assign zero_slot = (bus_addr == ADDR_W'(SLOT_SET)) || (bus_addr == ADDR_W'(SLOT_CLR)) ||
                     (bus_addr == ADDR_W'(SLOT_TGL)) || (bus_addr == ADDR_W'(SLOT_RSV6)) ||
                     (bus_addr == ADDR_W'(SLOT_RSV7));

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (pin_out == '0 && pin_oe == '0 && !bus_rvalid));

  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(SLOT_SET)) |=>
      ((pin_out & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(SLOT_CLR)) |=>
      ((pin_out & $past(bus_wdata)) == '0) &&
      ((pin_out & ~$past(bus_wdata)) == ($past(pin_out) & ~$past(bus_wdata))));

  a_r5_tgl_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(SLOT_TGL)) |=>
      (pin_out == ($past(pin_out) ^ $past(bus_wdata))));

  a_r8_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(SLOT_DIR)) |=> (pin_oe == $past(bus_wdata)));

  a_r9_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  a_r9_rvalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

  a_r6_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && zero_slot) |=> (bus_rdata == '0));

  a_r10_rsv_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == ADDR_W'(SLOT_RSV6) || bus_addr == ADDR_W'(SLOT_RSV7) ||
                bus_addr == ADDR_W'(SLOT_PIN))) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind gpio_bank gpio_bank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe)
);

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic        bus_rvalid;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  gpio_bank u_gpio_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  // Monitor: pops expected read data as results appear.
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (sb.size() == 0) chk("R9 unexpected rvalid", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb.pop_front();
        chk(it.tag, bus_rdata, it.exp);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    sb.push_back('{exp, tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rdwr(logic [2:0] a, logic [31:0] d, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    sb.push_back('{exp, tag});
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pin_out in reset", pin_out, 32'h0);
    chk("R1 pin_oe in reset", pin_oe, 32'h0);
    rst_n = 1'b1;
    rd(3'd0, 32'h0, "R1 latch after reset");
    rd(3'd5, 32'h0, "R1 dir after reset");

    wr(3'd0, 32'hA5A5_0F0F);
    chk("R2 pin_out after load", pin_out, 32'hA5A5_0F0F);
    rd(3'd0, 32'hA5A5_0F0F, "R2 latch readback");

    wr(3'd1, 32'h0000_F0F1);
    chk("R3 set", pin_out, 32'hA5A5_FFFF);
    wr(3'd1, 32'h0);
    chk("R3 set with zero mask", pin_out, 32'hA5A5_FFFF);

    wr(3'd2, 32'hFF00_0001);
    chk("R4 clear", pin_out, 32'h00A5_FFFE);

    wr(3'd3, 32'h0F0F_00FF);
    chk("R5 toggle", pin_out, 32'h0FAA_FF01);
    wr(3'd3, 32'h0F0F_00FF);
    chk("R5 toggle back", pin_out, 32'h00A5_FFFE);

    rd(3'd1, 32'h0, "R6 set reads zero");
    rd(3'd2, 32'h0, "R6 clear reads zero");
    rd(3'd3, 32'h0, "R6 toggle reads zero");

    wr(3'd5, 32'hFFFF_0000);
    chk("R8 pin_oe", pin_oe, 32'hFFFF_0000);
    chk("R8 pin_out untouched", pin_out, 32'h00A5_FFFE);
    rd(3'd5, 32'hFFFF_0000, "R8 dir readback");

    @(negedge clk);
    pin_in = 32'h1234_5678;
    rd(3'd4, 32'h0, "R7 sync latency");
    rd(3'd4, 32'h1234_5678, "R7 input level");
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'h1234_5678, "R7 input write ignored");
    chk("R7 latch unchanged by input write", pin_out, 32'h00A5_FFFE);
    chk("R7 dir unchanged by input write", pin_oe, 32'hFFFF_0000);

    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h5555_5555);
    chk("R10 latch unchanged", pin_out, 32'h00A5_FFFE);
    chk("R10 dir unchanged", pin_oe, 32'hFFFF_0000);
    rd(3'd6, 32'h0, "R10 index 6 reads zero");
    rd(3'd7, 32'h0, "R10 index 7 reads zero");

    rdwr(3'd0, 32'hDEAD_BEEF, 32'h00A5_FFFE, "R9 same-cycle read sees old");
    chk("R9 rvalid one cycle", {31'd0, bus_rvalid}, 32'd1);
    @(negedge clk);
    chk("R9 rvalid drops", {31'd0, bus_rvalid}, 32'd0);
    rd(3'd0, 32'hDEAD_BEEF, "R9 later read sees new");
    rdwr(3'd5, 32'h0000_00FF, 32'hFFFF_0000, "R9 same-cycle dir read");
    chk("R8 pin_oe after dir write", pin_oe, 32'h0000_00FF);

    repeat (3) @(negedge clk);
    chk("R9 scoreboard drained", sb.size(), 32'd0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got hung expected done");
      finish_run();
    end
  end
endmodule